// File: doc/BRIEF.md
# Run-time Configurable Serial Transmitter

This block sends bytes as asynchronous serial frames on a single output line. A byte enters through a valid/ready handshake. The block then produces a low start bit, then the data bits with the least significant bit first. An optional parity bit follows, and then one or two high stop bits. Between frames the line rests high.

Five control inputs set the frame shape. One selects 7 or 8 data bits, one turns parity on, one chooses even or odd parity, and one adds a second stop bit. A 2-bit code picks one of four standard bit rates. The bit period is derived from the system clock frequency parameter `CLK_HZ`. All controls are captured at the moment a byte is accepted, so the surrounding logic may change them freely while a frame is on the line.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: The bit period P is round(CLK_HZ / baud), with `rate_sel` 2'b00 = 9600, 2'b01 = 4800, 2'b10 = 2400 and 2'b11 = 1200 baud. Every bit of a frame lasts exactly P clock cycles.
- R3: A frame begins in the cycle after acceptance with one start bit, during which `txd` is 0.
- R4: When `len8` is 1, eight data bits follow the start bit, bit 0 of `in_data` first.
- R5: When `len8` is 0, only `in_data[6:0]` is sent, bit 0 first, and `in_data[7]` has no effect on the line.
- R6: When `par_en` is 1, one parity bit follows the last data bit. When `par_en` is 0, no parity bit is sent.
- R7: When `par_even` is 1, the parity bit makes the count of ones over the sent data bits plus the parity bit even. When `par_even` is 0, it makes that count odd.
- R8: Each frame ends with one high stop bit, or with two when `stop2` is 1.
- R9: Changes to `len8`, `par_en`, `par_even`, `stop2` or `rate_sel` after acceptance do not alter the frame in progress.
- R10: `in_ready` is 0 and `busy` is 1 from the cycle after acceptance until the last stop period ends. A new byte can be accepted in the first cycle after that.
- R11: `in_valid` asserted while a frame is in progress is ignored. It neither alters the frame nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted this cycle |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_en | input | 1 | 1 = insert a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop2 | input | 1 | 1 = two stop bits |
| rate_sel | input | 2 | Bit-rate code |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |

## Verification
Take the rising edge that accepts a byte as cycle 0. Frame bit j then spans cycles j*P up to (j+1)*P, so the bench samples `txd` at the falling edge in the middle of each bit, half a period away from any transition. `busy` must still be 1 at the falling edge of cycle T-1, where T is P times the frame's bit count. It must be 0, with `in_ready` back at 1, at the falling edge of cycle T. The next byte is offered at exactly that point, which proves back-to-back acceptance. The bench inverts the controls and raises `in_valid` with a different byte inside the frame. It then checks both the frame's bits and the idle cycles that follow.

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       stop2,
  input  logic [1:0] rate_sel,
  output logic       txd,
  output logic       busy
);
  localparam int PER0 = (CLK_HZ + 4800) / 9600;
  localparam int PER1 = (CLK_HZ + 2400) / 4800;
  localparam int PER2 = (CLK_HZ + 1200) / 2400;
  localparam int PER3 = (CLK_HZ + 600) / 1200;
  localparam int CW   = $clog2(PER3 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t        state;
  logic [CW-1:0] cnt, per_q, per_sel;
  logic [7:0]    shreg;
  logic [2:0]    idx;
  logic          len8_q, paren_q, stop2_q, par_q, stop_n;
  logic [7:0]    masked;

  always_comb begin
    case (rate_sel)
      2'b00:   per_sel = CW'(PER0 - 1);
      2'b01:   per_sel = CW'(PER1 - 1);
      2'b10:   per_sel = CW'(PER2 - 1);
      default: per_sel = CW'(PER3 - 1);
    endcase
  end

  assign masked   = len8 ? in_data : {1'b0, in_data[6:0]};
  assign busy     = (state != S_IDLE);
  assign in_ready = !busy;

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = shreg[0];
      S_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      per_q   <= '0;
      shreg   <= '0;
      idx     <= '0;
      len8_q  <= 1'b0;
      paren_q <= 1'b0;
      stop2_q <= 1'b0;
      par_q   <= 1'b0;
      stop_n  <= 1'b0;
    end else if (state == S_IDLE) begin
      if (in_valid) begin
        state   <= S_START;
        cnt     <= per_sel;
        per_q   <= per_sel;
        shreg   <= masked;
        len8_q  <= len8;
        paren_q <= par_en;
        stop2_q <= stop2;
        par_q   <= (^masked) ^ ~par_even;
        idx     <= '0;
        stop_n  <= 1'b0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= per_q;
      case (state)
        S_START: state <= S_DATA;
        S_DATA: begin
          shreg <= {1'b0, shreg[7:1]};
          if (idx == (len8_q ? 3'd7 : 3'd6))
            state <= paren_q ? S_PAR : S_STOP;
          else
            idx <= idx + 1'b1;
        end
        S_PAR: state <= S_STOP;
        default: begin
          if (stop2_q && !stop_n) stop_n <= 1'b1;
          else                    state  <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_uart_tx_chk.sv
module cfg_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy
);
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd && in_ready));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !txd));

  assert_stop_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));
endmodule

bind cfg_uart_tx cfg_uart_tx_chk chk_i (.*);

// File: tb/cfg_uart_tx_tb_top.sv
module cfg_uart_tx_tb_top;
  localparam int CLK_HZ = 96000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic len8 = 1'b1, par_en = 1'b0, par_even = 1'b0, stop2 = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic in_ready, txd, busy;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cfg_uart_tx #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .len8(len8), .par_en(par_en), .par_even(par_even),
    .stop2(stop2), .rate_sel(rate_sel), .txd(txd), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int period_of(input logic [1:0] r);
    case (r)
      2'b00:   return (CLK_HZ + 4800) / 9600;
      2'b01:   return (CLK_HZ + 2400) / 4800;
      2'b10:   return (CLK_HZ + 1200) / 2400;
      default: return (CLK_HZ + 600) / 1200;
    endcase
  endfunction

  // Called right after a falling edge; returns at the falling edge T cycles after acceptance.
  task automatic run_frame(input string tag, input logic [7:0] d, input logic l8,
                           input logic pe, input logic ev, input logic s2,
                           input logic [1:0] r, input logic poke);
    logic exp_bits[12];
    int nb, p, t;
    logic [7:0] m;
    m = l8 ? d : {1'b0, d[6:0]};
    nb = 0;
    exp_bits[nb++] = 1'b0;
    for (int i = 0; i < (l8 ? 8 : 7); i++) exp_bits[nb++] = m[i];
    if (pe) exp_bits[nb++] = (^m) ^ ~ev;
    exp_bits[nb++] = 1'b1;
    if (s2) exp_bits[nb++] = 1'b1;
    p = period_of(r);
    t = p * nb;

    in_data = d; len8 = l8; par_en = pe; par_even = ev; stop2 = s2; rate_sel = r;
    in_valid = 1'b1;
    chk({tag, " R10 ready before accept"}, in_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    len8 = ~l8; par_en = ~pe; par_even = ~ev; stop2 = ~s2; rate_sel = ~r;
    if (poke) begin in_valid = 1'b1; in_data = ~d; end
    for (int k = 0; k <= t; k++) begin
      if (k % p == p / 2)
        chk($sformatf("%s R2 R3 R4 R5 R6 R7 R8 R9 bit %0d", tag, k / p), txd, exp_bits[k / p]);
      if (k == 1) chk({tag, " R10 ready low in frame"}, in_ready, 1'b0);
      if (k == t - 1) begin
        chk({tag, " R2 R10 busy to end"}, busy, 1'b1);
        in_valid = 1'b0;
      end
      if (k == t) begin
        chk({tag, " R10 busy clear"}, busy, 1'b0);
        chk({tag, " R1 idle line"}, txd, 1'b1);
      end
      if (k < t) @(negedge clk);
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset ready", in_ready, 1'b1);
  endtask

  task automatic test_busy_poke;
    run_frame("R11 poke", 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11 no extra frame busy", busy, 1'b0);
      chk("R11 no extra frame txd", txd, 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_frame("R4 8N1", 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    run_frame("R5 7N1 b7", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    run_frame("R7 8E1", 8'h07, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0);
    run_frame("R7 8O2", 8'h07, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0);
    run_frame("R6 R7 7E2", 8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0);
    run_frame("R7 7O1", 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    run_frame("R8 8N2", 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
    test_busy_poke();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule